// File: doc/BRIEF.md
# SMBus Byte-Data Master with Status Interrupt

This block runs one SMBus byte-data transaction at a time against an external target with a 7-bit address. Software fills in a target address, a command byte and, for writes, a data byte through a small register bus. It then writes a one-shot start bit for either a write or a read. The engine drives SCL and SDA as open-drain lines. It sends the address phase, the command phase and either the data byte or a repeated start followed by a one-byte read. It ends every transaction with a stop condition.

Completion, a NACK from the target and a rising edge on an external client interrupt pin are latched in one write-1-to-clear status register. A mask register gates those bits, and the unmasked bits are ORed into a single level interrupt. The bit clock comes from `CLK_HZ` and `SCL_HZ`. Each bit takes four quarter periods of `CLK_HZ/(4*SCL_HZ)` cycles. While the engine releases SCL and the line stays low, the quarter counter waits, which gives simple clock-stretch tolerance.

Top module: `smb_byte_master`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 4'b0001, read data reads 0, the interrupt is low and both lines are released (sclOe = sdaOe = 0).
- R2: Writing 1 to control bit 0 runs a write transfer with these steps:
  - a start condition;
  - the byte {address, 0};
  - the command byte;
  - the write-data byte;
  - a stop condition.
- R3: Writing 1 to control bit 1 runs a read transfer with these steps:
  - a start condition;
  - the bytes {address, 0} and command;
  - a repeated start;
  - the byte {address, 1};
  - one byte received from the target and answered by the master with NACK (SDA released);
  - a stop condition.
  The received byte appears at the read-data offset.
- R4: At the end of a transfer, status bit 1 (write done) or bit 2 (read done) sets, according to the kind of transfer.
- R5: A NACK on any byte the master sends ends the transfer with a stop condition at once. It sets status bit 3 together with the done bit of that transfer kind, sends no further bytes and leaves read data unchanged.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event that arrives in the same cycle as the clear keeps its bit set.
- R7: Status bit 0 sets on a rising edge of clientIrqIn (after a two-flop synchronizer), whether or not it is masked. A level that stays high does not set it again once it is cleared.
- R8: irqOut is high exactly when some status bit is set whose mask bit is 0. A mask bit of 1 blocks its status bit.
- R9: A start written to control while a transfer is running is ignored, so the running transfer finishes unchanged.
- R10: The register offsets are:

  | Offset | Contents |
  |---|---|
  | 0 | control (reads 0) |
  | 1 | target address (bits 6:0 stored, bit 7 reads 0) |
  | 2 | command |
  | 3 | write data |
  | 4 | read data |
  | 5 | status (bits 3:0) |
  | 6 | mask (bits 3:0) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | AW | Register offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on regAddr) |
| clientIrqIn | input | 1 | Asynchronous interrupt from the external client |
| irqOut | output | 1 | Level interrupt, OR of unmasked status bits |
| sclIn | input | 1 | Sensed SCL line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaIn | input | 1 | Sensed SDA line level |
| sdaOe | output | 1 | Pull SDA low when 1 |

## Verification
Register contents can be read on the same cycle, because the read port is combinational. The start, status-clear and mask writes take effect on the edge that samples regWe, so the bench reads them back at the next falling edge. The status bits and irqOut move one cycle after the stop condition's last quarter. The bench therefore polls irqOut on falling edges before it inspects the status register and the bytes logged by the target model. A client edge reaches status bit 0 on the third clock edge after the pin rises. The bench waits five cycles for that. It also places the colliding clear write exactly on that third edge to test set-over-clear priority.

// File: rtl/smb_pkg.sv
package smb_pkg;
  // register offsets; the three payload bytes follow the control byte
  localparam int REG_CTRL = 0;
  localparam int REG_TGT  = 1;
  localparam int REG_CMD  = 2;
  localparam int REG_WDAT = 3;
  localparam int REG_RDAT = 4;
  localparam int REG_STAT = 5;
  localparam int REG_MASK = 6;

  localparam int NSTAT = 4;
  localparam logic [NSTAT-1:0] MASK_RST = 4'b0001;

  typedef enum logic [1:0] {SRC_ADDRW, SRC_ADDRR, SRC_CMD, SRC_WDAT} shSrc_t;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_BYTE, PH_RSTART, PH_STOP} phase_t;

  typedef struct packed {
    logic   shLoad;
    shSrc_t shSrc;
    logic   shStep;
    logic   inBit;
    logic   rxCapture;
    logic   finWr;
    logic   finRd;
    logic   finNack;
  } smbStrb_t;
endpackage

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int QTR_CYC = 500
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startWr,
  input  logic     startRd,
  input  logic     txBit,
  input  logic     sclIn,
  input  logic     sdaIn,
  output smbStrb_t strb,
  output logic     sclOe,
  output logic     sdaOe,
  output logic     busy,
  output logic     opRead
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(QTR_CYC - 1);

  phase_t phase;
  logic [1:0] q;
  logic [CW-1:0] cnt;
  logic [3:0] bitN;
  logic [1:0] byteIdx;
  logic nackQ, sampQ;
  logic sclRel, sdaRel, rxByte, hold, qEnd, phaseEnd;

  assign rxByte = opRead && (byteIdx == 2'd3);

  // line levels per phase and quarter (1 = released)
  always_comb begin
    sclRel = 1'b1;
    sdaRel = 1'b1;
    case (phase)
      PH_START:  begin sclRel = (q < 2'd2);              sdaRel = (q == 2'd0); end
      PH_RSTART: begin sclRel = (q == 2'd1 || q == 2'd2); sdaRel = (q < 2'd2); end
      PH_STOP:   begin sclRel = (q != 2'd0);             sdaRel = (q > 2'd1); end
      PH_BYTE: begin
        sclRel = (q == 2'd1 || q == 2'd2);
        sdaRel = (rxByte || bitN == 4'd8) ? 1'b1 : txBit;
      end
      default: ;
    endcase
  end

  assign sclOe    = !sclRel;
  assign sdaOe    = !sdaRel;
  assign busy     = (phase != PH_IDLE);
  assign hold     = sclRel && !sclIn;
  assign qEnd     = (cnt == CNT_TOP) && !hold;
  assign phaseEnd = qEnd && (q == 2'd3);

  always_comb begin
    strb = '0;
    strb.inBit = sampQ;
    if (phaseEnd) begin
      case (phase)
        PH_START:  begin strb.shLoad = 1'b1; strb.shSrc = SRC_ADDRW; end
        PH_RSTART: begin strb.shLoad = 1'b1; strb.shSrc = SRC_ADDRR; end
        PH_BYTE: begin
          if (bitN != 4'd8) strb.shStep = 1'b1;
          else if (rxByte) strb.rxCapture = 1'b1;
          else if (!sampQ) begin
            if (byteIdx == 2'd0) begin
              strb.shLoad = 1'b1; strb.shSrc = SRC_CMD;
            end else if (byteIdx == 2'd1 && !opRead) begin
              strb.shLoad = 1'b1; strb.shSrc = SRC_WDAT;
            end
          end
        end
        PH_STOP: begin
          strb.finWr   = !opRead;
          strb.finRd   = opRead;
          strb.finNack = nackQ;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; q <= '0; cnt <= '0; bitN <= '0; byteIdx <= '0;
      opRead <= 1'b0; nackQ <= 1'b0; sampQ <= 1'b0;
    end else if (phase == PH_IDLE) begin
      q <= '0;
      cnt <= '0;
      if (startWr || startRd) begin
        phase   <= PH_START;
        opRead  <= !startWr;
        nackQ   <= 1'b0;
        byteIdx <= '0;
        bitN    <= '0;
      end
    end else begin
      if (qEnd) cnt <= '0;
      else if (!hold) cnt <= cnt + 1'b1;
      if (qEnd) begin
        q <= q + 1'b1;
        if (q == 2'd1) sampQ <= sdaIn;
      end
      if (phaseEnd) begin
        case (phase)
          PH_START:  begin phase <= PH_BYTE; bitN <= '0; byteIdx <= 2'd0; end
          PH_RSTART: begin phase <= PH_BYTE; bitN <= '0; byteIdx <= 2'd2; end
          PH_BYTE: begin
            if (bitN != 4'd8) bitN <= bitN + 1'b1;
            else begin
              bitN <= '0;
              if (!rxByte && sampQ) begin
                nackQ <= 1'b1;
                phase <= PH_STOP;
              end else if (rxByte) phase <= PH_STOP;
              else if (byteIdx == 2'd0) byteIdx <= 2'd1;
              else if (byteIdx == 2'd1) begin
                if (opRead) phase <= PH_RSTART;
                else byteIdx <= 2'd2;
              end else begin
                if (opRead) byteIdx <= 2'd3;
                else phase <= PH_STOP;
              end
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_datapath.sv
module smb_datapath
  import smb_pkg::*;
#(
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [AW-1:0]    regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             clientIrqIn,
  input  smbStrb_t         strb,
  output logic             txBit,
  output logic             startWr,
  output logic             startRd,
  output logic             irqOut,
  output logic [NSTAT-1:0] statusQ,
  output logic [NSTAT-1:0] maskQ,
  output logic [7:0]       rdDataQ
);
  logic [6:0] tgtQ;
  logic [7:0] cmdQ, wdatQ, shQ;
  logic [SYNC-1:0] syncQ;
  logic lastQ, clientRise;
  logic [NSTAT-1:0] setBits, clrBits;
  logic wrCtrl, wrStat;

  assign wrCtrl  = regWe && (regAddr == AW'(REG_CTRL));
  assign wrStat  = regWe && (regAddr == AW'(REG_STAT));
  assign startWr = wrCtrl && regWrData[0];
  assign startRd = wrCtrl && regWrData[1] && !regWrData[0];
  assign txBit   = shQ[7];

  assign clientRise = syncQ[SYNC-1] && !lastQ;
  assign setBits    = {strb.finNack, strb.finRd, strb.finWr, clientRise};
  assign clrBits    = wrStat ? regWrData[NSTAT-1:0] : '0;
  assign irqOut     = |(statusQ & ~maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ <= '0; cmdQ <= '0; wdatQ <= '0; shQ <= '0; rdDataQ <= '0;
      statusQ <= '0; maskQ <= MASK_RST; syncQ <= '0; lastQ <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC-2:0], clientIrqIn};
      lastQ   <= syncQ[SYNC-1];
      statusQ <= (statusQ & ~clrBits) | setBits;
      if (regWe && regAddr == AW'(REG_TGT))  tgtQ  <= regWrData[6:0];
      if (regWe && regAddr == AW'(REG_CMD))  cmdQ  <= regWrData;
      if (regWe && regAddr == AW'(REG_WDAT)) wdatQ <= regWrData;
      if (regWe && regAddr == AW'(REG_MASK)) maskQ <= regWrData[NSTAT-1:0];
      if (strb.shLoad) begin
        case (strb.shSrc)
          SRC_ADDRW: shQ <= {tgtQ, 1'b0};
          SRC_ADDRR: shQ <= {tgtQ, 1'b1};
          SRC_CMD:   shQ <= cmdQ;
          default:   shQ <= wdatQ;
        endcase
      end else if (strb.shStep) shQ <= {shQ[6:0], strb.inBit};
      if (strb.rxCapture) rdDataQ <= shQ;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      AW'(REG_TGT):  regRdData = {1'b0, tgtQ};
      AW'(REG_CMD):  regRdData = cmdQ;
      AW'(REG_WDAT): regRdData = wdatQ;
      AW'(REG_RDAT): regRdData = rdDataQ;
      AW'(REG_STAT): regRdData = {{(8-NSTAT){1'b0}}, statusQ};
      AW'(REG_MASK): regRdData = {{(8-NSTAT){1'b0}}, maskQ};
      default:       regRdData = '0;
    endcase
  end
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master
  import smb_pkg::*;
#(
  parameter int AW     = 3,
  parameter int CLK_HZ = 200_000_000,
  parameter int SCL_HZ = 100_000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [7:0]    regWrData,
  output logic [7:0]    regRdData,
  input  logic          clientIrqIn,
  output logic          irqOut,
  input  logic          sclIn,
  output logic          sclOe,
  input  logic          sdaIn,
  output logic          sdaOe
);
  localparam int QTR_CYC = CLK_HZ / (4 * SCL_HZ);

  smbStrb_t strb;
  logic txBit, startWr, startRd, busy, opRead;
  logic [NSTAT-1:0] statusQ, maskQ;
  logic [7:0] rdDataQ;

  smb_ctrl #(.QTR_CYC(QTR_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
    .txBit(txBit), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .opRead(opRead)
  );

  smb_datapath #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .clientIrqIn(clientIrqIn),
    .strb(strb), .txBit(txBit), .startWr(startWr), .startRd(startRd),
    .irqOut(irqOut), .statusQ(statusQ), .maskQ(maskQ), .rdDataQ(rdDataQ)
  );
endmodule

// File: rtl/smb_byte_master_chk.sv
module smb_byte_master_chk
  import smb_pkg::*;
#(
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             opRead,
  input logic             startWr,
  input logic             startRd,
  input logic             finWr,
  input logic [NSTAT-1:0] statusQ,
  input logic [7:0]       rdDataQ,
  input logic             sclOe,
  input logic             sdaOe,
  input logic             regWe,
  input logic [AW-1:0]    regAddr,
  input logic [7:0]       regWrData
);
  // R2
  lines_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));

  // R3
  rdata_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdDataQ) |-> $past(busy && opRead));

  // R4
  rd_done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[2]) |-> $past(busy && opRead));

  // R5
  nack_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[3]) |-> (statusQ[1] || statusQ[2]));

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == AW'(REG_STAT) && regWrData[1] && !finWr) |=> !statusQ[1]);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (startWr || startRd)) |=> (busy && opRead == $past(opRead)));
endmodule

bind smb_byte_master smb_byte_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .opRead(opRead), .startWr(startWr),
  .startRd(startRd), .finWr(strb.finWr), .statusQ(statusQ), .rdDataQ(rdDataQ),
  .sclOe(sclOe), .sdaOe(sdaOe), .regWe(regWe), .regAddr(regAddr),
  .regWrData(regWrData)
);

// File: tb/test_smb_byte_master.sv
`timescale 1ns/1ps
module test_smb_byte_master;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  wire  [7:0] regRdData;
  logic clientIrq = 1'b0;
  wire  irqOut, sclOe, sdaOe;
  logic slvLow = 1'b0;
  wire  sclLine = !sclOe;
  wire  sdaLine = !(sdaOe || slvLow);

  smb_byte_master #(.AW(3), .CLK_HZ(200_000_000), .SCL_HZ(25_000_000)) i_smb_byte_master (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .clientIrqIn(clientIrq), .irqOut(irqOut),
    .sclIn(sclLine), .sclOe(sclOe), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  int total = 0, bad = 0;

  // target model
  int bitN = 0, byteCnt = 0, nackAt = 99, logN = 0, startCnt = 0, stopCnt = 0;
  logic armed = 1'b0, reading = 1'b0, firstByte = 1'b0, mNackSeen = 1'b0;
  logic [7:0] rxSh = '0, txByte = '0;
  logic [7:0] logB [0:7];

  always @(negedge sdaLine) if (rstN && sclLine === 1'b1) begin
    startCnt++; bitN = 0; armed = 1'b0; reading = 1'b0; firstByte = 1'b1;
  end
  always @(posedge sdaLine) if (rstN && sclLine === 1'b1) stopCnt++;
  always @(posedge sclLine) if (rstN && armed) begin
    if (bitN < 8) rxSh = {rxSh[6:0], sdaLine};
    else if (reading) mNackSeen = sdaLine;
  end
  always @(negedge sclLine) if (rstN) begin
    if (!armed) armed = 1'b1;
    else if (bitN < 8) begin
      bitN++;
      if (reading) slvLow = (bitN < 8) ? !txByte[7-bitN] : 1'b0;
      else if (bitN == 8) begin
        if (logN < 8) logB[logN] = rxSh;
        logN++;
        slvLow = (byteCnt != nackAt);
        byteCnt++;
      end
    end else begin
      bitN = 0;
      if (!reading && firstByte && rxSh[0] && slvLow) begin
        reading = 1'b1; slvLow = !txByte[7];
      end else begin
        reading = 1'b0; slvLow = 1'b0;
      end
      firstByte = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic clearLog();
    logN = 0; byteCnt = 0; startCnt = 0; stopCnt = 0; mNackSeen = 1'b0;
  endtask

  task automatic waitIrq(input string tag);
    int n = 0;
    while (!irqOut && n < 4000) begin @(negedge clk); n++; end
    chk({tag, " completion timeout"}, int'(irqOut), 1);
  endtask

  task automatic xfer(input bit isRd, input logic [6:0] a, input logic [7:0] c,
                      input logic [7:0] w, input int nk, input logic [7:0] tb);
    logic [7:0] prev, v;
    logic [7:0] exb [0:2];
    string t, tn;
    int expN;
    t  = isRd ? "R3" : "R2";
    tn = (nk < 3) ? "R5" : t;
    rd(4, prev);
    clearLog(); nackAt = nk; txByte = tb;
    wr(1, {1'b0, a}); wr(2, c); wr(3, w);
    wr(0, isRd ? 8'h02 : 8'h01);
    waitIrq("R4");
    exb[0] = {a, 1'b0}; exb[1] = c; exb[2] = isRd ? {a, 1'b1} : w;
    expN = (nk < 3) ? nk + 1 : 3;
    chk({tn, " byte count"}, logN, expN);
    for (int i = 0; i < 3; i++) if (i < expN) chk({t, " byte value"}, logB[i], exb[i]);
    chk({t, " starts"}, startCnt, (isRd && nk >= 2) ? 2 : 1);
    chk({tn, " stops"}, stopCnt, 1);
    rd(5, v);
    chk({(nk < 3) ? "R5" : "R4", " status"}, v, (isRd ? 4 : 2) | ((nk < 3) ? 8 : 0));
    rd(4, v);
    chk({tn, " read data"}, v, (isRd && nk >= 3) ? tb : prev);
    if (isRd && nk >= 3) chk("R3 master nack", mNackSeen, 1);
    wr(5, 8'h0F);
    rd(5, v);
    chk("R6 clear status", v, 0);
    chk("R8 irq after clear", irqOut, 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    rd(5, v); chk("R1 status", v, 0);
    rd(6, v); chk("R1 mask", v, 1);
    rd(4, v); chk("R1 read data", v, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 lines", {sclOe, sdaOe}, 0);

    // R10 readback
    wr(1, 8'hFF); rd(1, v); chk("R10 address width", v, 8'h7F);
    wr(2, 8'hA6); rd(2, v); chk("R10 command", v, 8'hA6);
    wr(3, 8'h5C); rd(3, v); chk("R10 write data", v, 8'h5C);
    wr(6, 8'hF3); rd(6, v); chk("R10 mask field", v, 8'h03);
    wr(6, 8'h01);
    rd(0, v); chk("R10 control reads zero", v, 0);

    // R2 R3 R4 R5 sweep over kind, nack position and patterns
    for (int op = 0; op < 2; op++)
      for (int nk = 0; nk < 4; nk++)
        for (int p = 0; p < 3; p++) begin
          logic [7:0] tb;
          tb = (p == 0) ? 8'h00 : ((p == 1) ? 8'hFF : 8'(8'h35 + nk * 8'h47));
          xfer(op[0], 7'((p * 37 + 11 + nk) & 7'h7F), 8'((p * 73 + 5) ^ nk),
               8'(8'hC3 ^ (p * 29)), (nk == 3) ? 99 : nk, tb);
        end

    // R9 start while busy is ignored
    clearLog(); nackAt = 99;
    wr(1, 8'h6B); wr(2, 8'h12); wr(3, 8'h34);
    wr(0, 8'h01);
    wr(0, 8'h02);
    waitIrq("R9");
    rd(5, v); chk("R9 status only write done", v, 2);
    chk("R9 byte count", logN, 3);
    chk("R9 starts", startCnt, 1);
    wr(5, 8'h0F);

    // R8 adapter bits masked
    wr(6, 8'h0F);
    clearLog();
    wr(0, 8'h01);
    repeat (1500) @(negedge clk);
    rd(5, v); chk("R8 status latched under mask", v, 2);
    chk("R8 irq masked", irqOut, 0);
    wr(6, 8'h01);
    @(negedge clk); chk("R8 irq after unmask", irqOut, 1);
    wr(5, 8'h0F);

    // R7 client edge
    clientIrq = 1'b1;
    repeat (5) @(negedge clk);
    rd(5, v); chk("R7 client bit set while masked", v, 1);
    chk("R8 client masked irq", irqOut, 0);
    wr(6, 8'h00);
    @(negedge clk); chk("R8 client unmasked irq", irqOut, 1);
    wr(5, 8'h01);
    repeat (4) @(negedge clk);
    rd(5, v); chk("R7 level does not re-set", v, 0);
    chk("R8 irq low after clear", irqOut, 0);
    clientIrq = 1'b0;
    repeat (5) @(negedge clk);

    // R6 event during clear stays latched
    clientIrq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd5; regWrData = 8'h01;
    @(negedge clk);
    regWe = 1'b0;
    rd(5, v); chk("R6 set wins over clear", v, 1);
    chk("R6 irq reasserted", irqOut, 1);
    wr(5, 8'h01);
    rd(5, v); chk("R6 clear without event", v, 0);
    wr(5, 8'h00);
    rd(5, v); chk("R6 zero write no effect", v, 0);
    wr(6, 8'h01);
    clientIrq = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R4 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule